// File: doc/BRIEF.md
# Auto-Triggered Multiply-Accumulate Unit

This block is a 16x16 hardware multiplier with a 40-bit accumulator, sitting on a simple register bus. Software loads two operand registers; the write that completes the operand set starts the operation by itself, with no separate start command. In that one clock edge the block forms the full 32-bit product and, in the accumulating modes, adds it into the accumulator. Both are readable on the bus straight after the triggering write.

Four operations are offered: plain multiply, square, multiply-accumulate and square-accumulate. In the square operations, a write to the first operand alone triggers and uses that value as both factors. In the other two, the write to the second operand triggers. Operands are treated as signed two's complement or as unsigned, chosen by a control bit. The accumulator carries 8 guard bits above the product, wraps on overflow and records the overflow in a sticky flag. A control bit clears both.

Top module: `mac_unit`

## Requirements
- R1: After reset, the control, both operand registers, the product, the accumulator and the overflow flag read as zero.
- R2: With operation code 0 (multiply), a write to the second operand (address 2) loads the product with first operand times the written value; the accumulator is unchanged.
- R3: With operation code 1 (square), a write to the first operand (address 1) loads the product with the written value squared; a write to address 2 leaves the product unchanged.
- R4: With operation code 2 (multiply-accumulate), a write to address 2 loads the product as in R2 and adds it into the accumulator; without a triggering write the accumulator holds its value.
- R5: With operation code 3 (square-accumulate), a write to address 1 loads the product as in R3 and adds it into the accumulator.
- R6: Control bit 2 set makes operands signed two's complement; clear makes them unsigned. The product is the low 32 bits of the exact result.
- R7: In operation codes 0 and 2, a write to address 1 stores the operand but changes neither product nor accumulator.
- R8: The accumulator is 40 bits; the product is sign-extended in signed mode and zero-extended in unsigned mode before addition, and the sum wraps modulo 2^40.
- R9: An addition that overflows (carry out of bit 39 in unsigned mode, sign overflow in signed mode) sets a sticky overflow flag, read at bit 4 of address 0, held until cleared.
- R10: Writing address 0 with bit 3 set clears accumulator and overflow flag; bit 3 reads back as 0. Bits [1:0] store the operation code and bit 2 the sign mode.
- R11: Reads: address 0 control/status, 1 and 2 operands, 3 and 4 product low/high half, 5, 6, 7 accumulator bits [15:0], [31:16], [39:32] zero-extended. Read data is zero while the read strobe is low.
- R12: Results are visible on a read issued in the cycle right after the triggering write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from registers |

## Verification
Every result lands on the clock edge that accepts the triggering write, and read data is a combinational view of the registers, so each result is due on a read issued in the very next cycle. The bench drives each write for exactly one edge starting at a falling edge, then reads back at the following falling edge, before any further edge, which checks R12 on every vector. Non-triggering writes are followed by readback of product and accumulator in the same way, so an unwanted update is caught within one cycle.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        OP_MUL   = 2'd0,
        OP_SQR   = 2'd1,
        OP_MAC   = 2'd2,
        OP_SQMAC = 2'd3
    } op_e;

    typedef struct packed {
        logic sgn;
        op_e  op;
    } ctrl_t;

    typedef enum logic [2:0] {
        A_CTRL = 3'd0,
        A_MA   = 3'd1,
        A_MB   = 3'd2,
        A_PLO  = 3'd3,
        A_PHI  = 3'd4,
        A_ALO  = 3'd5,
        A_AMID = 3'd6,
        A_AHI  = 3'd7
    } addr_e;

    localparam int CTRL_CLR_BIT = 3;
    localparam int CTRL_OVF_BIT = 4;

    function automatic logic is_square(op_e op);
        return (op == OP_SQR) || (op == OP_SQMAC);
    endfunction

    function automatic logic does_acc(op_e op);
        return (op == OP_MAC) || (op == OP_SQMAC);
    endfunction

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int W = 16
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           sgn,
    output logic [2*W-1:0] p
);
    localparam int FW = 2*W + 2;

    logic signed [W:0]    ea;
    logic signed [W:0]    eb;
    logic signed [FW-1:0] full;

    assign ea   = {sgn & a[W-1], a};
    assign eb   = {sgn & b[W-1], b};
    assign full = FW'(ea) * FW'(eb);
    assign p    = full[2*W-1:0];

endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
    parameter int PW    = 32,
    parameter int ACC_W = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             add_en,
    input  logic             sgn,
    input  logic [PW-1:0]    prod,
    output logic [ACC_W-1:0] acc,
    output logic             ovf
);
    localparam int GW = ACC_W - PW;

    logic [ACC_W-1:0] addend;
    logic [ACC_W:0]   sum;
    logic             wrap;

    assign addend = {{GW{sgn & prod[PW-1]}}, prod};
    assign sum    = {1'b0, acc} + {1'b0, addend};

    always_comb begin
        if (sgn)
            wrap = (acc[ACC_W-1] == addend[ACC_W-1]) && (sum[ACC_W-1] != acc[ACC_W-1]);
        else
            wrap = sum[ACC_W];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
            ovf <= 1'b0;
        end else if (add_en) begin
            acc <= sum[ACC_W-1:0];
            if (wrap)
                ovf <= 1'b1;
        end
    end

    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!add_en && !clr) |=> $stable(acc)) else $error("acc moved"); // R4
    AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc == '0) && !ovf) else $error("clear failed"); // R10
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr) |=> ovf) else $error("ovf dropped"); // R9
    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (acc == '0) && !ovf) else $error("reset state"); // R1

endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
    parameter int OP_W    = 16,
    parameter int GUARD_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [2:0]      addr,
    input  logic [OP_W-1:0] wdata,
    output logic [OP_W-1:0] rdata
);
    import mac_pkg::*;

    localparam int PW    = 2 * OP_W;
    localparam int ACC_W = PW + GUARD_W;

    ctrl_t            ctrl_q;
    logic [OP_W-1:0]  ma_q, mb_q;
    logic [PW-1:0]    prod_q, prod_c;
    logic [ACC_W-1:0] acc;
    logic             ovf;
    logic [OP_W-1:0]  fa, fb;
    logic             wr_ctrl, wr_ma, wr_mb, trig, clr;
    addr_e            ra;

    assign wr_ctrl = wr_en && (addr == A_CTRL);
    assign wr_ma   = wr_en && (addr == A_MA);
    assign wr_mb   = wr_en && (addr == A_MB);
    assign trig    = is_square(ctrl_q.op) ? wr_ma : wr_mb;
    assign clr     = wr_ctrl && wdata[CTRL_CLR_BIT];

    assign fa = is_square(ctrl_q.op) ? wdata : ma_q;
    assign fb = wdata;

    mac_mult #(.W(OP_W)) u_mult (
        .a   (fa),
        .b   (fb),
        .sgn (ctrl_q.sgn),
        .p   (prod_c)
    );

    mac_accum #(.PW(PW), .ACC_W(ACC_W)) u_acc (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr),
        .add_en (trig && does_acc(ctrl_q.op)),
        .sgn    (ctrl_q.sgn),
        .prod   (prod_c),
        .acc    (acc),
        .ovf    (ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ma_q   <= '0;
            mb_q   <= '0;
            prod_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= ctrl_t'(wdata[2:0]);
            if (wr_ma)   ma_q   <= wdata;
            if (wr_mb)   mb_q   <= wdata;
            if (trig)    prod_q <= prod_c;
        end
    end

    always_comb begin
        ra    = addr_e'(addr);
        rdata = '0;
        if (rd_en) begin
            case (ra)
                A_CTRL: begin
                    rdata[2:0]          = ctrl_q;
                    rdata[CTRL_OVF_BIT] = ovf;
                end
                A_MA:   rdata = ma_q;
                A_MB:   rdata = mb_q;
                A_PLO:  rdata = prod_q[OP_W-1:0];
                A_PHI:  rdata = prod_q[PW-1:OP_W];
                A_ALO:  rdata = acc[OP_W-1:0];
                A_AMID: rdata = acc[PW-1:OP_W];
                A_AHI:  rdata[GUARD_W-1:0] = acc[ACC_W-1:PW];
                default: rdata = '0;
            endcase
        end
    end

    AST_PROD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !trig |=> $stable(prod_q)) else $error("product moved"); // R3
    AST_MA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_ma |=> $stable(ma_q)) else $error("operand moved"); // R7

endmodule

// File: tb/sim_mac_unit.sv
module sim_mac_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en;
    logic [2:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;

    int n_run  = 0;
    int n_fail = 0;
    logic [39:0] m_acc = '0;
    logic        m_ovf = 1'b0;
    logic [31:0] m_prod = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_unit u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
                 .addr(addr), .wdata(wdata), .rdata(rdata));

    // op[1:0], sgn, ma, mb
    localparam int NV = 10;
    localparam logic [34:0] VEC [NV] = '{
        {2'd0, 1'b0, 16'd3,     16'd7},
        {2'd0, 1'b0, 16'hFFFF,  16'hFFFF},
        {2'd0, 1'b1, 16'hFFFF,  16'd5},
        {2'd1, 1'b1, 16'h8000,  16'd9},
        {2'd1, 1'b0, 16'h1234,  16'd1},
        {2'd2, 1'b0, 16'd100,   16'd200},
        {2'd2, 1'b1, 16'hFFF0,  16'd300},
        {2'd3, 1'b1, 16'hFF00,  16'd0},
        {2'd3, 1'b0, 16'hABCD,  16'd0},
        {2'd2, 1'b1, 16'h7FFF,  16'h8000}
    };

    function automatic logic [31:0] ref_mul(logic sg, logic [15:0] a, logic [15:0] b);
        longint sa, sb;
        sa = sg ? longint'($signed(a)) : longint'(a);
        sb = sg ? longint'($signed(b)) : longint'(b);
        return 32'(sa * sb);
    endfunction

    task automatic ref_add(logic sg, logic [31:0] p);
        logic [39:0] ad;
        logic [40:0] s;
        ad = sg ? {{8{p[31]}}, p} : {8'd0, p};
        s  = {1'b0, m_acc} + {1'b0, ad};
        if (sg ? ((m_acc[39] == ad[39]) && (s[39] != m_acc[39])) : s[40]) m_ovf = 1'b1;
        m_acc = s[39:0];
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rd_prod(output logic [31:0] p);
        logic [15:0] lo, hi;
        rd(3'd3, lo); rd(3'd4, hi);
        p = {hi, lo};
    endtask

    task automatic rd_acc(output logic [39:0] v);
        logic [15:0] lo, mid, hi;
        rd(3'd5, lo); rd(3'd6, mid); rd(3'd7, hi);
        v = {hi[7:0], mid, lo};
        check("R11 acc top bits zero", 64'(hi[15:8]), 64'd0);
    endtask

    task automatic rd_ovf(output logic o);
        logic [15:0] c;
        rd(3'd0, c);
        o = c[4];
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [31:0] p;
        logic [39:0] a;
        logic        o;
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), d);
            check("R1 reset reg", 64'(d), 64'd0);
        end

        // R11 read strobe low gives zero
        wr(3'd1, 16'h5A5A);
        addr = 3'd1; #1;
        check("R11 idle rdata", 64'(rdata), 64'd0);
        rd(3'd1, d);
        check("R11 MA readback", 64'(d), 64'h5A5A);

        // vector walk: R2 R3 R4 R5 R6 R7 R12
        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic        sg;
            logic [15:0] va, vb;
            {op, sg, va, vb} = VEC[i];
            wr(3'd0, {13'd0, sg, op});
            rd(3'd0, d);
            check("R10 ctrl readback", 64'(d[3:0]), 64'({1'b0, sg, op}));
            wr(3'd1, va);
            if (op[0]) begin
                m_prod = ref_mul(sg, va, va);
                if (op[1]) ref_add(sg, m_prod);
                rd_prod(p); check("R3 R5 R12 square product", 64'(p), 64'(m_prod));
                rd_acc(a);  check("R5 square acc", 64'(a), 64'(m_acc));
                wr(3'd2, vb);
                rd_prod(p); check("R3 MB write ignored", 64'(p), 64'(m_prod));
                rd_acc(a);  check("R3 acc unchanged", 64'(a), 64'(m_acc));
            end else begin
                rd_prod(p); check("R7 MA write no trigger", 64'(p), 64'(m_prod));
                rd_acc(a);  check("R7 acc unchanged", 64'(a), 64'(m_acc));
                wr(3'd2, vb);
                m_prod = ref_mul(sg, va, vb);
                if (op[1]) ref_add(sg, m_prod);
                rd_prod(p); check("R2 R4 R6 R12 product", 64'(p), 64'(m_prod));
                rd_acc(a);  check("R2 R4 R8 acc", 64'(a), 64'(m_acc));
            end
        end
        rd_ovf(o); check("R9 no overflow yet", 64'(o), 64'(m_ovf));

        // R10 clear
        wr(3'd0, 16'h000A);
        m_acc = '0; m_ovf = 1'b0;
        rd_acc(a); check("R10 clear acc", 64'(a), 64'd0);
        rd(3'd0, d); check("R10 clear bit reads 0", 64'(d[4:0]), 64'h2);

        // R8 R9 unsigned wrap: 257 x FFFF*FFFF
        wr(3'd1, 16'hFFFF);
        for (int k = 0; k < 257; k++) begin
            wr(3'd2, 16'hFFFF);
            ref_add(1'b0, 32'hFFFE0001);
            if (k == 255) begin
                rd_ovf(o); check("R9 no ovf at 256", 64'(o), 64'd0);
            end
        end
        rd_acc(a); check("R8 unsigned wrap value", 64'(a), 64'(m_acc));
        check("R8 model wrap value", 64'(m_acc), 64'h00FDFE0101);
        rd_ovf(o); check("R9 unsigned overflow set", 64'(o), 64'd1);
        wr(3'd2, 16'd1);
        ref_add(1'b0, 32'h0000FFFF);
        rd_ovf(o); check("R9 overflow sticky", 64'(o), 64'd1);

        // R9 signed overflow: 512 x (-32768)^2
        wr(3'd0, 16'h000E);
        m_acc = '0; m_ovf = 1'b0;
        wr(3'd1, 16'h8000);
        for (int k = 0; k < 512; k++) begin
            wr(3'd2, 16'h8000);
            ref_add(1'b1, 32'h40000000);
            if (k == 510) begin
                rd_ovf(o); check("R9 signed no ovf at 511", 64'(o), 64'd0);
            end
        end
        rd_acc(a); check("R8 signed wrap value", 64'(a), 64'(m_acc));
        rd_ovf(o); check("R9 signed overflow set", 64'(o), 64'd1);

        // R6 signed negative accumulation sign-extends
        wr(3'd0, 16'h000E);
        m_acc = '0; m_ovf = 1'b0;
        wr(3'd1, 16'hFFFF);
        wr(3'd2, 16'd2);
        rd_acc(a); check("R6 R8 negative acc", 64'(a), 64'hFFFFFFFFFE);
        rd_ovf(o); check("R9 no ovf on negative", 64'(o), 64'd0);

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd_acc(a); check("R1 reset clears acc", 64'(a), 64'd0);
        rd(3'd0, d); check("R1 reset clears ctrl", 64'(d), 64'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule